// File: doc/BRIEF.md
# DMA Completion Action Unit

This unit runs the bookkeeping a DMA engine owes once a transfer has finished. The engine hands over the finished instruction's header fields, the byte total and two mode bits. The unit then updates one of two completion counters and one of two sticky forced-interrupt flags. It also issues at most one follow-up request: a work-queue entry submission, a single-byte zero write to local memory, or, in per-core notify mode, an increment of a small per-core counter bank.

Counting and the interrupt flags apply only to transfers that write toward the host side: outbound and external-only. A header bit chooses between the two counters and the two flags. The pointer field and the work-queue bit decide the follow-up action. A zero pointer means no follow-up action. A work-queue pointer that is not 8-byte aligned is refused, and the unit pulses an error output instead. While a follow-up request waits on its ready, the unit takes no new completion.

Top module: `dma_done_actions`

## Requirements
- R1: The transfer type uses the encoding 0 outbound, 1 inbound, 2 internal-only, 3 external-only. Only types 0 and 3 may change a completion counter or a forced-interrupt flag; completions of type 1 or 2 leave both counters and both flags unchanged.
- R2: The counter-select bit routes the update to counter 0 and flag 0 when it is 0, and to counter 1 and flag 1 when it is 1. The other counter and flag do not change.
- R3: An accepted type-0 or type-3 completion with counter-add set grows the selected counter by 1 when `cfg_add_one` is 1, and by `cpl_bytes` otherwise. The new value shows on the clock edge that accepts the completion. With counter-add clear, no counter changes.
- R4: An accepted type-0 or type-3 completion with force-interrupt set sets the selected bit of `fint` at the accepting edge. The bit stays set until it is cleared.
- R5: Completion counters and per-core notify counters saturate at all-ones and never wrap.
- R6: A 1 on a bit of `clr_cnt`, `clr_fint` or `clr_notify` clears that item at the next edge. When a clear and an increment hit the same counter in the same cycle, the result is the increment applied to zero. When a set and a clear hit the same flag in the same cycle, the flag ends set.
- R7: With the work-queue bit at 1 and a nonzero pointer whose bits [2:0] are zero, the unit raises `wq_valid` with `wq_ptr` equal to the pointer at the accepting edge. It holds both until the edge on which `wq_ready` is 1.
- R8: With the work-queue bit at 0 and a nonzero pointer, and the notify case of R10 not applying, the unit raises `zw_valid` with `zw_addr` equal to the pointer. It holds both until `zw_ready`.
- R9: A completion with a zero pointer raises no request, no error and no notify increment.
- R10: With `cfg_core_notify` at 1, the work-queue bit at 0 and a pointer in 1..63, the unit issues no zero write. Instead the notify counter of core (pointer[5:0] − 1) grows by 1. An index of `NUM_CORES` or more has no effect.
- R11: With the work-queue bit at 1, a nonzero pointer and any of bits [2:0] set, the unit raises no request. It drives `bad_align` high for exactly the one cycle after the accepting edge.
- R12: `cpl_ready` is 1 exactly when no follow-up request is pending, and at most one completion is accepted per edge. After reset both counters, both flags, all notify counters and both request valids are 0, and `cpl_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpl_valid | input | 1 | Completion offered |
| cpl_ready | output | 1 | Completion can be taken this cycle |
| cpl_type | input | 2 | Transfer type (0 out, 1 in, 2 internal, 3 external) |
| cpl_csel | input | 1 | Counter and flag select |
| cpl_cadd | input | 1 | Add to the selected counter |
| cpl_fint | input | 1 | Set the selected forced-interrupt flag |
| cpl_wq | input | 1 | Pointer is a work-queue entry |
| cpl_ptr | input | PTR_W | Post-action pointer |
| cpl_bytes | input | BYTE_W | Total bytes of the transfer |
| cfg_add_one | input | 1 | Count completions rather than bytes |
| cfg_core_notify | input | 1 | Small pointers bump a per-core counter |
| clr_cnt | input | 2 | Write-one-to-clear for the completion counters |
| clr_fint | input | 2 | Write-one-to-clear for the forced-interrupt flags |
| clr_notify | input | NUM_CORES | Write-one-to-clear for the notify counters |
| cnt0 | output | CNT_W | Completion counter 0 |
| cnt1 | output | CNT_W | Completion counter 1 |
| fint | output | 2 | Forced-interrupt flags |
| notify_cnt | output | NUM_CORES*NCNT_W | Per-core notify counters, core c at bits [c*NCNT_W +: NCNT_W] |
| wq_valid | output | 1 | Work-entry submission pending |
| wq_ready | input | 1 | Work-entry submission taken |
| wq_ptr | output | PTR_W | Work-entry pointer |
| zw_valid | output | 1 | Zero-byte write pending |
| zw_ready | input | 1 | Zero-byte write taken |
| zw_addr | output | PTR_W | Address of the byte to clear |
| bad_align | output | 1 | One-cycle pulse for a refused misaligned work pointer |

## Verification
A counter with the wrong value, or a wrong select, is visible on `cnt0`, `cnt1` or `fint` on the same edge that accepts the completion. The bench compares these each cycle, so such a fault is caught within one clock. A stuck or lost request valid appears at once as a wrong `cpl_ready`, and the completion stream stalls. A wrong decode of the pointer shows as a request, error pulse or notify bump that appears or goes missing one cycle after the accepting edge. Saturation and same-cycle clear faults show only at the all-ones or clear boundary, so the bench drives those boundaries directly.

// File: rtl/dda_pkg.sv
package dda_pkg;

  typedef enum logic [1:0] {
    XFER_OUT   = 2'd0,
    XFER_IN    = 2'd1,
    XFER_LOCAL = 2'd2,
    XFER_EXT   = 2'd3
  } xfer_e;

  // Transfers that write toward the host side may count and interrupt.
  function automatic logic writes_host(input logic [1:0] t);
    return (xfer_e'(t) == XFER_OUT) || (xfer_e'(t) == XFER_EXT);
  endfunction

endpackage

// File: rtl/dda_sat_counter.sv
module dda_sat_counter #(
  parameter int W  = 8,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  value
);

  localparam int SW = ((W > IW) ? W : IW) + 1;

  logic [W-1:0]  value_q;
  logic [W-1:0]  value_d;
  logic [W-1:0]  base;
  logic [SW-1:0] sum;
  logic [SW-1:0] max_v;
  logic          en;

  always_comb begin
    base    = clr ? '0 : value_q;
    max_v   = {{(SW-W){1'b0}}, {W{1'b1}}};
    sum     = {{(SW-W){1'b0}}, base} +
              (add_en ? {{(SW-IW){1'b0}}, inc} : '0);
    value_d = (sum > max_v) ? {W{1'b1}} : sum[W-1:0];
    en      = clr | add_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  value_q <= '0;
    else if (en) value_q <= value_d;
  end

  assign value = value_q;

  // R5: an add without a clear never makes the value smaller
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !clr) |=> (value >= $past(value)));

endmodule

// File: rtl/dda_req_slot.sv
module dda_req_slot #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);

  logic         valid_q, valid_d;
  logic [W-1:0] data_q;

  always_comb begin
    valid_d = valid_q;
    if (valid_q && ready) valid_d = 1'b0;
    if (load)             valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= din;
  end

  assign valid = valid_q;
  assign data  = data_q;

  // R7 / R8: a waiting request keeps its valid and its payload
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));

  // R12: a new request never lands on a pending one
  assert_no_overwrite_R12: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid);

endmodule

// File: rtl/dma_done_actions.sv
module dma_done_actions
  import dda_pkg::*;
#(
  parameter int PTR_W     = 40,
  parameter int BYTE_W    = 16,
  parameter int CNT_W     = 32,
  parameter int NUM_CORES = 8,
  parameter int NCNT_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpl_valid,
  output logic                        cpl_ready,
  input  logic [1:0]                  cpl_type,
  input  logic                        cpl_csel,
  input  logic                        cpl_cadd,
  input  logic                        cpl_fint,
  input  logic                        cpl_wq,
  input  logic [PTR_W-1:0]            cpl_ptr,
  input  logic [BYTE_W-1:0]           cpl_bytes,
  input  logic                        cfg_add_one,
  input  logic                        cfg_core_notify,
  input  logic [1:0]                  clr_cnt,
  input  logic [1:0]                  clr_fint,
  input  logic [NUM_CORES-1:0]        clr_notify,
  output logic [CNT_W-1:0]            cnt0,
  output logic [CNT_W-1:0]            cnt1,
  output logic [1:0]                  fint,
  output logic [NUM_CORES*NCNT_W-1:0] notify_cnt,
  output logic                        wq_valid,
  input  logic                        wq_ready,
  output logic [PTR_W-1:0]            wq_ptr,
  output logic                        zw_valid,
  input  logic                        zw_ready,
  output logic [PTR_W-1:0]            zw_addr,
  output logic                        bad_align
);

  localparam int IDX_W = 6;

  logic             accept;
  logic             host_upd;
  logic             ptr_nz;
  logic             low_ok;
  logic             ptr_small;
  logic             wq_go;
  logic             zw_go;
  logic             notify_hit;
  logic             err_d, err_q;
  logic [IDX_W-1:0] core_idx;
  logic [BYTE_W-1:0] cnt_inc;
  logic [1:0]       fint_d, fint_q;
  logic [CNT_W-1:0] cnt_v [2];

  // Decode of the accepted completion
  always_comb begin
    cpl_ready  = !wq_valid && !zw_valid;
    accept     = cpl_valid && cpl_ready;
    host_upd   = accept && writes_host(cpl_type);
    ptr_nz     = |cpl_ptr;
    low_ok     = (cpl_ptr[2:0] == 3'd0);
    ptr_small  = (cpl_ptr[PTR_W-1:IDX_W] == '0);
    wq_go      = accept && cpl_wq && ptr_nz && low_ok;
    err_d      = accept && cpl_wq && ptr_nz && !low_ok;
    notify_hit = accept && cfg_core_notify && !cpl_wq && ptr_nz && ptr_small;
    zw_go      = accept && !cpl_wq && ptr_nz && !(cfg_core_notify && ptr_small);
    core_idx   = cpl_ptr[IDX_W-1:0] - IDX_W'(1);
    cnt_inc    = cfg_add_one ? BYTE_W'(1) : cpl_bytes;
    for (int i = 0; i < 2; i++) begin
      fint_d[i] = (fint_q[i] && !clr_fint[i]) ||
                  (host_upd && cpl_fint && (cpl_csel == i[0]));
    end
  end

  // Completion counters, one per select value
  for (genvar i = 0; i < 2; i++) begin : g_cnt
    dda_sat_counter #(.W(CNT_W), .IW(BYTE_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_cnt[i]),
      .add_en (host_upd && cpl_cadd && (cpl_csel == 1'(i))),
      .inc    (cnt_inc),
      .value  (cnt_v[i])
    );
  end

  // Per-core notify counters
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    dda_sat_counter #(.W(NCNT_W), .IW(1)) u_ncnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_notify[c]),
      .add_en (notify_hit && (core_idx == IDX_W'(c))),
      .inc    (1'b1),
      .value  (notify_cnt[c*NCNT_W +: NCNT_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fint_q <= 2'b00;
      err_q  <= 1'b0;
    end else begin
      fint_q <= fint_d;
      err_q  <= err_d;
    end
  end

  dda_req_slot #(.W(PTR_W)) u_wq (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wq_go),
    .din   (cpl_ptr),
    .ready (wq_ready),
    .valid (wq_valid),
    .data  (wq_ptr)
  );

  dda_req_slot #(.W(PTR_W)) u_zw (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (zw_go),
    .din   (cpl_ptr),
    .ready (zw_ready),
    .valid (zw_valid),
    .data  (zw_addr)
  );

  assign cnt0      = cnt_v[0];
  assign cnt1      = cnt_v[1];
  assign fint      = fint_q;
  assign bad_align = err_q;

  // R1: inbound and internal-only completions leave the counters alone
  assert_local_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !writes_host(cpl_type) && (clr_cnt == 2'b00))
      |=> ($stable(cnt0) && $stable(cnt1)));

  // R12: the two request kinds are never pending together
  assert_one_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wq_valid && zw_valid));

  // R11: a refused work pointer produces no submission
  assert_err_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_align |-> !wq_valid);

  // R9: a zero pointer leads to no follow-up at all
  assert_zero_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cpl_ptr == '0)) |=> (!wq_valid && !zw_valid && !bad_align));

  // R10: a notify bump replaces the zero write
  assert_notify_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    notify_hit |=> !zw_valid);

endmodule

// File: tb/sim_dma_done_actions.sv
`timescale 1ns/1ps
module sim_dma_done_actions;

  localparam int PTR_W = 40;
  localparam int BYTE_W = 8;
  localparam int CNT_W = 10;
  localparam int NUM_CORES = 4;
  localparam int NCNT_W = 3;
  localparam longint CMAX = (1 << CNT_W) - 1;
  localparam longint NMAX = (1 << NCNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpl_valid = 1'b0;
  logic cpl_ready;
  logic [1:0] cpl_type = 2'd0;
  logic cpl_csel = 1'b0, cpl_cadd = 1'b0, cpl_fint = 1'b0, cpl_wq = 1'b0;
  logic [PTR_W-1:0] cpl_ptr = '0;
  logic [BYTE_W-1:0] cpl_bytes = '0;
  logic cfg_add_one = 1'b0, cfg_core_notify = 1'b0;
  logic [1:0] clr_cnt = 2'b00, clr_fint = 2'b00;
  logic [NUM_CORES-1:0] clr_notify = '0;
  logic [CNT_W-1:0] cnt0, cnt1;
  logic [1:0] fint;
  logic [NUM_CORES*NCNT_W-1:0] notify_cnt;
  logic wq_valid, zw_valid, bad_align;
  logic wq_ready = 1'b1, zw_ready = 1'b1;
  logic [PTR_W-1:0] wq_ptr, zw_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dma_done_actions #(
    .PTR_W(PTR_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W),
    .NUM_CORES(NUM_CORES), .NCNT_W(NCNT_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_type(cpl_type), .cpl_csel(cpl_csel), .cpl_cadd(cpl_cadd),
    .cpl_fint(cpl_fint), .cpl_wq(cpl_wq), .cpl_ptr(cpl_ptr),
    .cpl_bytes(cpl_bytes), .cfg_add_one(cfg_add_one),
    .cfg_core_notify(cfg_core_notify), .clr_cnt(clr_cnt), .clr_fint(clr_fint),
    .clr_notify(clr_notify), .cnt0(cnt0), .cnt1(cnt1), .fint(fint),
    .notify_cnt(notify_cnt), .wq_valid(wq_valid), .wq_ready(wq_ready),
    .wq_ptr(wq_ptr), .zw_valid(zw_valid), .zw_ready(zw_ready),
    .zw_addr(zw_addr), .bad_align(bad_align)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  longint m_cnt [2];
  bit     m_fint [2];
  longint m_ncnt [NUM_CORES];
  bit     m_wqv, m_zwv, m_err;
  longint m_wqp, m_zwa;
  bit     live = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_fint[i] = 0; end
      for (int c = 0; c < NUM_CORES; c++) m_ncnt[c] = 0;
      m_wqv = 0; m_zwv = 0; m_err = 0; m_wqp = 0; m_zwa = 0;
    end else begin
      bit rdy, acc, host;
      longint p;
      rdy  = !m_wqv && !m_zwv;
      acc  = cpl_valid && rdy;
      host = (cpl_type == 2'd0) || (cpl_type == 2'd3);
      p    = longint'(cpl_ptr);
      if (m_wqv && wq_ready) m_wqv = 0;
      if (m_zwv && zw_ready) m_zwv = 0;
      for (int i = 0; i < 2; i++) begin
        longint b;
        b = clr_cnt[i] ? 0 : m_cnt[i];
        if (acc && host && cpl_cadd && (int'(cpl_csel) == i))
          b = b + (cfg_add_one ? 1 : longint'(cpl_bytes));
        m_cnt[i] = (b > CMAX) ? CMAX : b;
        if (clr_fint[i]) m_fint[i] = 0;
        if (acc && host && cpl_fint && (int'(cpl_csel) == i)) m_fint[i] = 1;
      end
      for (int c = 0; c < NUM_CORES; c++) begin
        longint b;
        b = clr_notify[c] ? 0 : m_ncnt[c];
        if (acc && cfg_core_notify && !cpl_wq && p > 0 && p < 64 && (p - 1) == c)
          b = b + 1;
        m_ncnt[c] = (b > NMAX) ? NMAX : b;
      end
      m_err = acc && cpl_wq && p != 0 && (p % 8) != 0;
      if (acc && cpl_wq && p != 0 && (p % 8) == 0) begin m_wqv = 1; m_wqp = p; end
      if (acc && !cpl_wq && p != 0 && !(cfg_core_notify && p < 64)) begin
        m_zwv = 1; m_zwa = p;
      end
    end
    #2;
    if (rst_n && live) begin
      check("R3 cnt0", cnt0, m_cnt[0]);
      check("R3 cnt1", cnt1, m_cnt[1]);
      check("R4 fint0", fint[0], m_fint[0]);
      check("R4 fint1", fint[1], m_fint[1]);
      for (int c = 0; c < NUM_CORES; c++)
        check("R10 notify", notify_cnt[c*NCNT_W +: NCNT_W], m_ncnt[c]);
      check("R7 wq_valid", wq_valid, m_wqv);
      if (m_wqv) check("R7 wq_ptr", wq_ptr, m_wqp);
      check("R8 zw_valid", zw_valid, m_zwv);
      if (m_zwv) check("R8 zw_addr", zw_addr, m_zwa);
      check("R11 bad_align", bad_align, m_err);
      check("R12 cpl_ready", cpl_ready, !m_wqv && !m_zwv);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog act=%0d exp<=20000", cycles);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic send(input logic [1:0] t, input logic cs, input logic ca,
                      input logic fi, input logic wq, input longint p,
                      input int nb);
    @(negedge clk);
    cpl_type = t; cpl_csel = cs; cpl_cadd = ca; cpl_fint = fi; cpl_wq = wq;
    cpl_ptr = PTR_W'(p); cpl_bytes = BYTE_W'(nb); cpl_valid = 1'b1;
    while (!cpl_ready) @(negedge clk);
    @(negedge clk);
    cpl_valid = 1'b0;
    clr_cnt = 2'b00; clr_fint = 2'b00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1;
    @(negedge clk);
    // reset state
    check("R12 reset cnt0", cnt0, 0);
    check("R12 reset cnt1", cnt1, 0);
    check("R12 reset fint", fint, 0);
    check("R12 reset ready", cpl_ready, 1);
    check("R12 reset wq_valid", wq_valid, 0);

    // outbound, byte mode, counter 0
    send(2'd0, 0, 1, 0, 0, 0, 5);
    check("R1 R3 outbound bytes", cnt0, 5);
    check("R9 zero ptr no write", zw_valid, 0);
    // external-only to counter 1 with interrupt
    send(2'd3, 1, 1, 1, 0, 0, 7);
    check("R2 cnt1 selected", cnt1, 7);
    check("R2 cnt0 untouched", cnt0, 5);
    check("R2 R4 flag1 only", fint, 2'b10);
    // inbound and internal-only do nothing
    send(2'd1, 0, 1, 1, 0, 0, 9);
    check("R1 inbound no count", cnt0, 5);
    send(2'd2, 0, 1, 1, 0, 0, 9);
    check("R1 internal no flag", fint, 2'b10);
    // add-one mode, and counter-add clear
    cfg_add_one = 1'b1;
    send(2'd0, 0, 1, 0, 0, 0, 200);
    check("R3 add one", cnt0, 6);
    send(2'd0, 0, 0, 0, 0, 0, 200);
    check("R3 cadd clear", cnt0, 6);
    cfg_add_one = 1'b0;
    // saturation of counter 1
    for (int k = 0; k < 5; k++) send(2'd3, 1, 1, 0, 0, 0, 255);
    check("R5 saturate", cnt1, CMAX);
    // clear alone, then clear together with an add and a flag set
    @(negedge clk); clr_cnt = 2'b10; clr_fint = 2'b10;
    @(negedge clk); clr_cnt = 2'b00; clr_fint = 2'b00;
    check("R6 clear cnt1", cnt1, 0);
    check("R6 clear flag1", fint, 2'b00);
    @(negedge clk);
    cpl_type = 2'd0; cpl_csel = 0; cpl_cadd = 1; cpl_fint = 1; cpl_wq = 0;
    cpl_ptr = '0; cpl_bytes = 8'd3; cpl_valid = 1'b1;
    clr_cnt = 2'b01; clr_fint = 2'b01;
    @(negedge clk);
    cpl_valid = 1'b0; clr_cnt = 2'b00; clr_fint = 2'b00;
    check("R6 clear plus add", cnt0, 3);
    check("R6 set beats clear", fint, 2'b01);

    // work submission held against ready
    wq_ready = 1'b0;
    send(2'd1, 0, 0, 0, 1, 'h100, 1);
    idle(3);
    check("R7 wq held", wq_valid, 1);
    check("R7 wq ptr", wq_ptr, 'h100);
    check("R12 ready low while pending", cpl_ready, 0);
    wq_ready = 1'b1;
    @(negedge clk);
    check("R7 wq released", wq_valid, 0);
    // zero-byte write, with a short stall
    zw_ready = 1'b0;
    send(2'd0, 0, 0, 0, 0, 'h1235, 1);
    check("R8 zero write addr", zw_addr, 'h1235);
    idle(2);
    zw_ready = 1'b1;
    idle(1);
    // misaligned work pointer
    send(2'd0, 0, 0, 0, 1, 'h101, 1);
    check("R11 error pulse", bad_align, 1);
    check("R11 no submit", wq_valid, 0);
    @(negedge clk);
    check("R11 pulse ends", bad_align, 0);

    // per-core notify
    cfg_core_notify = 1'b1;
    send(2'd2, 0, 0, 0, 0, 3, 1);
    check("R10 core2 bump", notify_cnt[2*NCNT_W +: NCNT_W], 1);
    check("R10 no zero write", zw_valid, 0);
    send(2'd2, 0, 0, 0, 0, 5, 1);
    check("R10 out of range core", notify_cnt, 1 << (2*NCNT_W));
    send(2'd2, 0, 0, 0, 0, 64, 1);
    check("R10 R8 ptr 64 writes", zw_valid, 1);
    idle(1);
    send(2'd2, 0, 0, 0, 0, 0, 1);
    check("R9 zero ptr nothing", zw_valid, 0);
    for (int k = 0; k < 9; k++) send(2'd2, 0, 0, 0, 0, 1, 1);
    check("R5 notify saturate", notify_cnt[0 +: NCNT_W], NMAX);
    @(negedge clk); clr_notify = 4'b0001;
    @(negedge clk); clr_notify = '0;
    check("R6 notify clear", notify_cnt[0 +: NCNT_W], 0);
    cfg_core_notify = 1'b0;
    idle(3);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule